// File: doc/BRIEF.md
# Serial Receiver with Per-Character Line Status

This block is the receive half of a classic asynchronous serial port. It samples a serial input `rxd` on a bit-rate enable that pulses sixteen times per bit. It rebuilds each character from a start bit, 5 to 8 data bits sent LSB first, an optional parity bit and one stop bit. It then stores the character together with its own error tags, in either a 16-deep queue or a single holding slot.

A host reads characters and a five-bit line status word through two one-cycle read strobes. Parity, framing and break tags belong to one character and appear in the status word only while that character is at the head of the queue. The overrun indication is a sticky flag for the whole receiver. A maskable interrupt request is raised whenever any of the four error indications is showing. After a bad stop bit the receiver does not wait for the line to go idle: it takes that low level as the start of the next character. A break produces exactly one zero character, and reception stays halted until the line has been high for a full bit time.

Top module: `uart_rx_lsr`

## Requirements
- R1: A character starts when `rxd` is low on 8 consecutive `sample_en` ticks. Each data bit is taken every 16 ticks after that, LSB first. The bit count is `word_len`+5 (0 gives 5 bits, 3 gives 8 bits), and the unused upper bits of `rd_data` read as 0.
- R2: When `parity_en` is 1, one parity bit follows the data. With `parity_even`=1 the data and parity ones must add up to an even count, and with 0 to an odd count. A mismatch tags the character with a parity error, shown in `rx_status[2]`.
- R3: With `fifo_en`=1 up to 16 characters are held in arrival order. With `fifo_en`=0 the receiver holds only one. `rx_status[0]` is 1 while at least one character is held and drops to 0 once the last one has been read.
- R4: A character that completes while storage is full is discarded. It sets the overrun flag `rx_status[1]`, which stays set until a status read (`rd_lsr_req`).
- R5: `rx_status[2]` (parity), `rx_status[3]` (framing) and `rx_status[4]` (break) show the tags of the head character only. A status read hides them for that character, while a later character keeps its own tags.
- R6: A stop bit sampled low tags the character with a framing error. The receiver takes that low level as the next start bit, checks it on one more tick, and then receives the following character.
- R7: If the start bit, all data bits, the parity bit (when enabled) and the stop bit are all low, a single character 0x00 is stored with only the break tag set. Nothing more is received until `rxd` has been high on 16 consecutive ticks.
- R8: `rls_irq` equals `rls_ie` AND the OR of `rx_status[4:1]`.
- R9: `rd_data` shows the head character, or 0 when empty. `rd_data_req` removes the head, and a read while empty has no effect.
- R10: After reset nothing is held, `rx_status` is 0, `rd_data` is 0 and `rls_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Oversampling tick, 16 per bit |
| rxd | input | 1 | Serial receive line, idle high |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| parity_even | input | 1 | 1 even parity, 0 odd parity |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 the single slot |
| rls_ie | input | 1 | Line-status interrupt enable |
| rd_data_req | input | 1 | Pop the head character |
| rd_lsr_req | input | 1 | Status read: clears overrun, hides head tags |
| rd_data | output | 8 | Head character |
| rx_status | output | 5 | {break, framing, parity, overrun, data ready} |
| rls_irq | output | 1 | Receiver line-status interrupt request |

## Verification
The bench builds a faulty character with a good one right behind it. A design that kept sticky tags would then show the wrong parity or framing state for the clean character. In a second case, a character follows a low stop bit with no idle gap between them. A receiver that waited for idle after a framing error would lose or shift that character. Break is held far longer than a frame, so a design that stored more than one zero character would be caught. The bench also overruns both the 16-entry queue and the single slot: a design that overwrote stored data, or never raised or cleared the overrun flag, would return the wrong bytes or status.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic       bi;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_entry_t;

  // shift register fills from the top; right-align the received bits
  function automatic logic [7:0] align_word(input logic [7:0] sh, input logic [1:0] wl);
    return sh >> (2'd3 - wl);
  endfunction

  function automatic logic [2:0] last_bit_idx(input logic [1:0] wl);
    return {1'b1, wl};
  endfunction

  function automatic logic parity_bit(input logic [7:0] d, input logic even);
    return even ? (^d) : ~(^d);
  endfunction

endpackage

// File: rtl/rx_deser.sv
module rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sample_en,
  input  logic      rxd,
  input  logic [1:0] word_len,
  input  logic      parity_en,
  input  logic      parity_even,
  output logic      frame_done,
  output rx_entry_t frame_entry
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;
  st_t         state;
  logic [CW-1:0] cnt;
  logic [2:0]  bit_idx;
  logic [7:0]  shreg;
  logic        par_bad, all_zero;

  logic       bit_tick, brk_seen, stop_bad;
  logic [7:0] word;
  assign bit_tick = (cnt == CW'(OVS - 1));
  assign word     = align_word(shreg, word_len);
  assign brk_seen = all_zero & ~rxd;
  assign stop_bad = ~rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; bit_idx <= '0; shreg <= '0;
      par_bad <= 1'b0; all_zero <= 1'b0; frame_done <= 1'b0; frame_entry <= '0;
    end else begin
      frame_done <= 1'b0;
      if (sample_en) begin
        case (state)
          S_IDLE: if (!rxd) begin
            state <= S_START; cnt <= CW'(1); bit_idx <= '0; shreg <= '0;
            par_bad <= 1'b0; all_zero <= 1'b1;
          end
          S_START: begin
            if (rxd) state <= S_IDLE;
            else if (cnt == CW'(HALF - 1)) begin state <= S_DATA; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (bit_tick) begin
              cnt <= '0;
              shreg <= {rxd, shreg[7:1]};
              all_zero <= all_zero & ~rxd;
              if (bit_idx == last_bit_idx(word_len)) state <= parity_en ? S_PAR : S_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (bit_tick) begin
              cnt <= '0;
              par_bad <= (rxd != parity_bit(word, parity_even));
              all_zero <= all_zero & ~rxd;
              state <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (bit_tick) begin
              frame_done <= 1'b1;
              cnt <= '0;
              if (brk_seen) begin
                frame_entry <= '{bi: 1'b1, fe: 1'b0, pe: 1'b0, data: 8'h00};
                state <= S_BRK;
              end else begin
                frame_entry <= '{bi: 1'b0, fe: stop_bad, pe: par_bad, data: word};
                if (!stop_bad) state <= S_IDLE;
                else begin
                  // low stop bit is taken as the next start bit: one more check
                  state <= S_START; cnt <= CW'(HALF - 1); bit_idx <= '0;
                  shreg <= '0; par_bad <= 1'b0; all_zero <= 1'b1;
                end
              end
            end else cnt <= cnt + 1'b1;
          end
          S_BRK: begin
            if (!rxd) cnt <= '0;
            else if (bit_tick) begin state <= S_IDLE; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_frame_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(sample_en));
  assert_break_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_entry.bi) |-> (state == S_BRK));
  assert_resync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_entry.fe) |-> (state == S_START));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_one,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CNTW-1:0] count;
  logic do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = cap_one ? !empty : (count == CNTW'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign head  = mem[rptr];

  always_ff @(posedge clk) if (do_wr) mem[wptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CNTW'(do_wr) - CNTW'(do_rd);
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));
  assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> $stable(count));
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> empty);
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_en,
  input  logic       rxd,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       parity_even,
  input  logic       fifo_en,
  input  logic       rls_ie,
  input  logic       rd_data_req,
  input  logic       rd_lsr_req,
  output logic [7:0] rd_data,
  output logic [4:0] rx_status,
  output logic       rls_irq
);
  localparam int EW = $bits(rx_entry_t);

  logic      frame_done;
  rx_entry_t frame_entry, head;
  logic      fifo_full, fifo_empty, pop, ovr_event;
  logic      oe_q, head_ack;

  rx_deser #(.OVS(OVS)) u_deser (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd),
    .word_len(word_len), .parity_en(parity_en), .parity_even(parity_even),
    .frame_done(frame_done), .frame_entry(frame_entry)
  );

  rx_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .cap_one(!fifo_en),
    .wr_en(frame_done), .wr_data(frame_entry), .rd_en(rd_data_req),
    .head(head), .full(fifo_full), .empty(fifo_empty)
  );

  assign pop       = rd_data_req && !fifo_empty;
  assign ovr_event = frame_done && fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0; head_ack <= 1'b0;
    end else begin
      if (ovr_event) oe_q <= 1'b1;
      else if (rd_lsr_req) oe_q <= 1'b0;
      if (pop) head_ack <= 1'b0;
      else if (rd_lsr_req && !fifo_empty) head_ack <= 1'b1;
    end
  end

  logic tag_vis;
  assign tag_vis   = !fifo_empty && !head_ack;
  assign rx_status = {tag_vis & head.bi, tag_vis & head.fe, tag_vis & head.pe, oe_q, !fifo_empty};
  assign rd_data   = fifo_empty ? 8'h00 : head.data;
  assign rls_irq   = rls_ie && (|rx_status[4:1]);

  assert_oe_on_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_event |=> rx_status[1]);
  assert_lsr_clears_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr_req && !ovr_event) |=> !rx_status[1]);
  assert_dr_after_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !fifo_full) |=> rx_status[0]);
  assert_tags_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr_req && !pop) |=> (rx_status[4:2] == 3'b000));
  assert_irq_on_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_event |=> (rls_irq || !rls_ie));
endmodule

// File: tb/tb_uart_rx_lsr.sv
module tb_uart_rx_lsr;
  logic clk = 1'b0, rst_n = 1'b0, sample_en = 1'b0, rxd = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic parity_en = 1'b0, parity_even = 1'b0, fifo_en = 1'b1, rls_ie = 1'b0;
  logic rd_data_req = 1'b0, rd_lsr_req = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] rx_status;
  logic rls_irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int tick_div = 0;
  localparam int BITCLK = 64;

  uart_rx_lsr dut (.*);

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    tick_div  <= (tick_div == 3) ? 0 : tick_div + 1;
    sample_en <= (tick_div == 3);
  end

  // every-clock comparison of the interrupt against the observed status (R8)
  always @(negedge clk) if (rst_n && !done) begin
    n_cmp++;
    if (rls_irq !== (rls_ie & (|rx_status[4:1]))) begin
      n_bad++; $display("FAIL R8 irq act=%b exp=%b", rls_irq, rls_ie & (|rx_status[4:1]));
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin n_bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk) rxd = b;
    repeat (BITCLK - 1) @(negedge clk);
  endtask

  function automatic logic ref_par(input logic [7:0] d, input int nb, input logic even);
    int ones = 0;
    for (int i = 0; i < nb; i++) ones += d[i];
    return even ? logic'(ones % 2) : logic'((ones + 1) % 2);
  endfunction

  task automatic frame(input logic [7:0] d, input logic flip_par, input logic stop);
    int nb = word_len + 5;
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) bit_out(d[i]);
    if (parity_en) bit_out(ref_par(d, nb, parity_even) ^ flip_par);
    bit_out(stop);
    bit_out(1'b1);
  endtask

  task automatic read_lsr(input string tag, input int exp);
    @(negedge clk);
    chk(tag, rx_status, exp);
    rd_lsr_req = 1'b1;
    @(negedge clk) rd_lsr_req = 1'b0;
  endtask

  task automatic read_dat(input string tag, input int exp);
    @(negedge clk);
    chk(tag, rd_data, exp);
    rd_data_req = 1'b1;
    @(negedge clk) rd_data_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 status", rx_status, 0); chk("R10 irq", rls_irq, 0); chk("R10 data", rd_data, 0);
    repeat (BITCLK) @(negedge clk);

    // R1/R3: two 8-bit characters in order
    frame(8'hA5, 1'b0, 1'b1); frame(8'h3C, 1'b0, 1'b1);
    chk("R3 dr set", rx_status, 5'b00001);
    read_dat("R1 first", 8'hA5); chk("R3 dr held", rx_status, 5'b00001);
    read_dat("R1 second", 8'h3C); chk("R3 dr clear", rx_status, 0);

    // R1/R2: 5-bit even parity, good
    word_len = 2'd0; parity_en = 1'b1; parity_even = 1'b1;
    frame(8'h15, 1'b0, 1'b1);
    read_lsr("R2 good parity", 5'b00001); read_dat("R1 5-bit", 8'h15);

    // R2/R5/R8: 7-bit odd parity, wrong
    word_len = 2'd2; parity_even = 1'b0; rls_ie = 1'b1;
    frame(8'h5A, 1'b1, 1'b1);
    @(negedge clk) chk("R8 irq on pe", rls_irq, 1);
    read_lsr("R2 pe", 5'b00101); read_lsr("R5 pe hidden", 5'b00001);
    chk("R8 irq off", rls_irq, 0);
    read_dat("R1 7-bit", 8'h5A);

    // R5: tag follows its own character
    word_len = 2'd3; parity_even = 1'b1;
    frame(8'h11, 1'b0, 1'b1); frame(8'h22, 1'b1, 1'b1);
    read_lsr("R5 clean head", 5'b00001); read_dat("R5 d0", 8'h11);
    read_lsr("R5 tagged head", 5'b00101); read_dat("R5 d1", 8'h22);

    // R6: low stop bit doubles as next start bit
    parity_en = 1'b0;
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(logic'((8'h81 >> i) & 1));
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(logic'((8'h7E >> i) & 1));
    bit_out(1'b1); bit_out(1'b1);
    read_lsr("R6 fe", 5'b01001); read_dat("R6 bad char", 8'h81);
    read_lsr("R6 resync clean", 5'b00001); read_dat("R6 next char", 8'h7E);

    // R7: long break yields one zero character
    for (int i = 0; i < 12; i++) bit_out(1'b0);
    bit_out(1'b1); bit_out(1'b1);
    read_lsr("R7 bi", 5'b10001); read_dat("R7 zero", 8'h00);
    chk("R7 single char", rx_status, 0);
    frame(8'h42, 1'b0, 1'b1);
    read_dat("R7 restart", 8'h42);

    // R4/R3: overrun of the 16-entry queue
    for (int i = 0; i < 17; i++) frame(8'h30 + 8'(i), 1'b0, 1'b1);
    @(negedge clk) chk("R8 irq on oe", rls_irq, 1);
    read_lsr("R4 oe set", 5'b00011); read_lsr("R4 oe cleared", 5'b00001);
    for (int i = 0; i < 16; i++) read_dat("R3 fifo order", 8'h30 + i);
    chk("R3 drained", rx_status, 0);

    // R3/R4: single slot mode
    fifo_en = 1'b0;
    frame(8'h55, 1'b0, 1'b1); frame(8'h66, 1'b0, 1'b1);
    read_lsr("R4 single slot oe", 5'b00011); read_dat("R3 slot keeps first", 8'h55);
    chk("R3 slot empty", rx_status, 0);

    // R9: read while empty has no effect
    read_dat("R9 empty data", 8'h00);
    chk("R9 empty status", rx_status, 0);
    frame(8'h99, 1'b0, 1'b1);
    read_dat("R9 after empty read", 8'h99);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule